// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the arithmetic unit of a 32-bit processor pipeline. Each accepted operation takes two 32-bit operands. The first is always a register value. The second is either a register value or a 16-bit immediate, zero-extended. The block returns a 32-bit result, five status flags, an exception request with its vector number, and a separate indication that a division could not be carried out. The result appears one clock after the operation is accepted. Operand fetch and write-back belong to the surrounding pipeline.

The unit covers the following operations:
- add and subtract
- the three bitwise logic operations
- logical left shift, logical right shift and arithmetic right shift
- signed and unsigned multiply, returning the low word
- signed and unsigned division

Division does not iterate. The divisor's magnitude is split into a power of two and an odd remainder. The dividend's magnitude is shifted right by the exponent of that power. It is then multiplied by a 17-bit reciprocal of the odd part, scaled by 2^16 and truncated, and the product is shifted right by 16. The reciprocals come from a small table that is generated from a parameter limiting the largest odd factor. A division by zero requests exception vector 0. Any arithmetic overflow requests vector 2.

Top module: `int_alu`

## Requirements
- R1: The outputs `result`, `flags`, `out_valid`, `exc_req`, `exc_vec` and `div_unsup` are all zero in reset. A result is registered one clock after the cycle in which `in_valid` is high. In a cycle after one with `in_valid` low, `out_valid`, `exc_req`, `div_unsup` and `exc_vec` are 0, while `result` and `flags` keep their last values.
- R2: With `use_imm` high, the second operand is `{16'b0, imm}` and `rs2` is ignored. With `use_imm` low, the second operand is `rs2`.
- R3: Add (op 0) and subtract (op 1) return the 32-bit wrapped sum or difference. Carry is the carry out of bit 31 for add and the inverted borrow for subtract. Overflow is set when both inputs to the adder have the same sign and the result has the other sign; for subtract, the adder's second input is the complemented second operand.
- R4: XOR (op 2), OR (op 3) and AND (op 4) return the bitwise result and clear carry and overflow.
- R5: Shift left (op 5), logical shift right (op 6) and arithmetic shift right (op 7) use only bits 4:0 of the second operand as the shift amount, and clear carry and overflow.
- R6: Signed multiply (op 8) and unsigned multiply (op 9) return the low 32 bits of the 64-bit product. Overflow is set when the high half differs from the sign extension of the low half (signed) or is nonzero (unsigned). Carry is 0.
- R7: Unsigned divide (op 11) with divisor d = 2^k * m, m odd and m no greater than ODD_MAX (63 by default), returns ((a >> k) * floor(65536 / m)) >> 16, truncated toward zero, so 8000/192 gives 41 and 3/3 gives 0.
- R8: Signed divide (op 10) applies the R7 rule to the operand magnitudes and negates the quotient when the operand signs differ. If the quotient is positive with bit 31 set (0x80000000 / -1), the result is 0x80000000 with overflow set.
- R9: A divide with a zero second operand returns 0, does not set overflow, and raises `exc_req` with `exc_vec` = 0.
- R10: Whenever the overflow flag of an accepted operation is set, `exc_req` is raised with `exc_vec` = 2.
- R11: A nonzero divisor whose odd part exceeds ODD_MAX returns 0 with `div_unsup` high and no exception.
- R12: The flag bits are carry [0], overflow [1], zero [2], sign [3] and odd [4]. Zero is set when the result is 0, sign equals result bit 31, and odd equals result bit 0. Division clears carry.
- R13: Op codes 12 to 15 return 0 with carry and overflow clear (flags = 5'b00100) and no exception or `div_unsup`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 4 | Operation code |
| use_imm | input | 1 | Second operand from `imm` instead of `rs2` |
| rs1 | input | 32 | First operand |
| rs2 | input | 32 | Second register operand |
| imm | input | 16 | Immediate, zero-extended |
| result | output | 32 | Registered result |
| flags | output | 5 | Registered flags {odd, sign, zero, overflow, carry} |
| out_valid | output | 1 | Result registered from the previous cycle |
| exc_req | output | 1 | Exception requested |
| exc_vec | output | 8 | Exception vector (0 divide by zero, 2 overflow) |
| div_unsup | output | 1 | Divisor outside the reciprocal table |

## Verification
The hardest region to reach is the part of division where the reciprocal approximation, the sign handling and the table limit interact. This covers:
- the truncating case where an exact quotient comes out one low (3/3)
- the largest odd divisor still in the table, and the first odd divisor outside it
- the single signed pair whose quotient magnitude does not fit (0x80000000 / -1)

Each of these needs a divisor chosen for its factorisation into a power of two and an odd part. The vector table therefore pairs dividends with divisors picked for that factorisation: 192 = 64*3, 63, 65, 4 taken from the immediate, and -1. Zero is given both as a register divisor and as an immediate divisor, which checks that the exception vector wins over every other outcome.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int XLEN  = 32;
  localparam int SHW   = $clog2(XLEN);
  localparam logic [7:0] VEC_DIV0 = 8'd0;
  localparam logic [7:0] VEC_OVF  = 8'd2;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_XOR  = 4'd2,
    OP_OR   = 4'd3,
    OP_AND  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_SAR  = 4'd7,
    OP_MUL  = 4'd8,
    OP_MULU = 4'd9,
    OP_DIV  = 4'd10,
    OP_DIVU = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic odd;
    logic sign;
    logic zero;
    logic ovf;
    logic carry;
  } alu_flags_t;

  function automatic logic [XLEN:0] add_carry(input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b,
                                              input logic cin);
    return {1'b0, a} + {1'b0, b} + {{XLEN{1'b0}}, cin};
  endfunction

  function automatic logic same_sign_flip(input logic [XLEN-1:0] a,
                                          input logic [XLEN-1:0] b,
                                          input logic [XLEN-1:0] r);
    return (a[XLEN-1] == b[XLEN-1]) && (r[XLEN-1] != a[XLEN-1]);
  endfunction

  function automatic logic [2*XLEN-1:0] mul_full(input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] b,
                                                 input logic sgn);
    logic [2*XLEN-1:0] ea;
    logic [2*XLEN-1:0] eb;
    ea = {{XLEN{sgn & a[XLEN-1]}}, a};
    eb = {{XLEN{sgn & b[XLEN-1]}}, b};
    return ea * eb;
  endfunction

  function automatic logic mul_high_lost(input logic [2*XLEN-1:0] p,
                                         input logic sgn);
    if (sgn) return p[2*XLEN-1:XLEN] != {XLEN{p[XLEN-1]}};
    return p[2*XLEN-1:XLEN] != '0;
  endfunction

  function automatic logic [SHW-1:0] low_zero_count(input logic [XLEN-1:0] v);
    logic [SHW-1:0] n;
    n = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (v[i]) n = SHW'(i);
    end
    return n;
  endfunction

  function automatic logic [XLEN-1:0] magnitude(input logic [XLEN-1:0] v,
                                                input logic sgn);
    return (sgn && v[XLEN-1]) ? (~v + 1'b1) : v;
  endfunction

endpackage

// File: rtl/alu_recip_table.sv
module alu_recip_table
  import alu_pkg::*;
#(
  parameter int ODD_MAX = 63,
  parameter int FRAC    = 16
) (
  input  logic [XLEN-1:0] odd_i,
  output logic [FRAC:0]   recip_o,
  output logic            hit_o
);

  localparam int N     = (ODD_MAX + 1) / 2;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [63:0] ONE_SCALED = 64'd1 << FRAC;

  logic [FRAC:0]      entry_w [N];
  logic [IDX_W-1:0]   idx_w;

  // one entry per odd divisor 1, 3, 5, ... ODD_MAX
  for (genvar g = 0; g < N; g++) begin : g_entry
    localparam logic [63:0] ENT = ONE_SCALED / (2 * g + 1);
    assign entry_w[g] = ENT[FRAC:0];
  end

  assign idx_w   = odd_i[IDX_W:1];
  assign hit_o   = odd_i[0] && (odd_i <= XLEN'(ODD_MAX));
  assign recip_o = hit_o ? entry_w[idx_w] : '0;

endmodule

// File: rtl/alu_divider.sv
module alu_divider
  import alu_pkg::*;
#(
  parameter int ODD_MAX = 63,
  parameter int FRAC    = 16
) (
  input  logic [XLEN-1:0] num_i,
  input  logic [XLEN-1:0] den_i,
  input  logic            is_signed_i,
  output logic [XLEN-1:0] quo_o,
  output logic            div0_o,
  output logic            unsup_o,
  output logic            ovf_o
);

  localparam int PW = XLEN + FRAC + 1;

  logic [XLEN-1:0] mag_n, mag_d, odd_part, scaled;
  logic [SHW-1:0]  pow2;
  logic [FRAC:0]   recip;
  logic            hit;
  logic [PW-1:0]   prod;
  logic [XLEN-1:0] quo_mag;
  logic            neg;

  assign mag_n    = magnitude(num_i, is_signed_i);
  assign mag_d    = magnitude(den_i, is_signed_i);
  assign pow2     = low_zero_count(mag_d);
  assign odd_part = mag_d >> pow2;
  assign scaled   = mag_n >> pow2;

  alu_recip_table #(.ODD_MAX(ODD_MAX), .FRAC(FRAC)) u_table (
    .odd_i   (odd_part),
    .recip_o (recip),
    .hit_o   (hit)
  );

  assign prod    = {{(FRAC + 1){1'b0}}, scaled} * {{XLEN{1'b0}}, recip};
  assign quo_mag = XLEN'(prod >> FRAC);
  assign neg     = is_signed_i & (num_i[XLEN-1] ^ den_i[XLEN-1]);

  assign div0_o  = (den_i == '0);
  assign unsup_o = !div0_o && !hit;

  always_comb begin
    if (div0_o || unsup_o) begin
      quo_o = '0;
      ovf_o = 1'b0;
    end else begin
      quo_o = neg ? (~quo_mag + 1'b1) : quo_mag;
      ovf_o = is_signed_i & !neg & quo_mag[XLEN-1];
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int ODD_MAX = 63,
  parameter int FRAC    = 16
) (
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output alu_flags_t      flags_o,
  output logic            div0_o,
  output logic            unsup_o
);

  alu_op_e           op_e;
  logic [XLEN:0]     sum_w, diff_w;
  logic [2*XLEN-1:0] prod_w;
  logic              mul_sgn, div_sgn, is_div;
  logic [XLEN-1:0]   quo_w;
  logic              dv_div0, dv_unsup, dv_ovf;
  logic [SHW-1:0]    shamt;
  logic [XLEN-1:0]   r;
  logic              c, v;

  assign op_e    = alu_op_e'(op_i);
  assign shamt   = b_i[SHW-1:0];
  assign sum_w   = add_carry(a_i, b_i, 1'b0);
  assign diff_w  = add_carry(a_i, ~b_i, 1'b1);
  assign mul_sgn = (op_e == OP_MUL);
  assign prod_w  = mul_full(a_i, b_i, mul_sgn);
  assign div_sgn = (op_e == OP_DIV);
  assign is_div  = (op_e == OP_DIV) || (op_e == OP_DIVU);

  alu_divider #(.ODD_MAX(ODD_MAX), .FRAC(FRAC)) u_div (
    .num_i       (a_i),
    .den_i       (b_i),
    .is_signed_i (div_sgn),
    .quo_o       (quo_w),
    .div0_o      (dv_div0),
    .unsup_o     (dv_unsup),
    .ovf_o       (dv_ovf)
  );

  always_comb begin
    r = '0;
    c = 1'b0;
    v = 1'b0;
    case (op_e)
      OP_ADD: begin
        r = sum_w[XLEN-1:0];
        c = sum_w[XLEN];
        v = same_sign_flip(a_i, b_i, r);
      end
      OP_SUB: begin
        r = diff_w[XLEN-1:0];
        c = diff_w[XLEN];
        v = same_sign_flip(a_i, ~b_i, r);
      end
      OP_XOR:  r = a_i ^ b_i;
      OP_OR:   r = a_i | b_i;
      OP_AND:  r = a_i & b_i;
      OP_SHL:  r = a_i << shamt;
      OP_SHR:  r = a_i >> shamt;
      OP_SAR:  r = XLEN'($signed(a_i) >>> shamt);
      OP_MUL, OP_MULU: begin
        r = prod_w[XLEN-1:0];
        v = mul_high_lost(prod_w, mul_sgn);
      end
      OP_DIV, OP_DIVU: begin
        r = quo_w;
        v = dv_ovf;
      end
      default: r = '0;
    endcase
  end

  assign res_o         = r;
  assign flags_o.carry = c;
  assign flags_o.ovf   = v;
  assign flags_o.zero  = (r == '0);
  assign flags_o.sign  = r[XLEN-1];
  assign flags_o.odd   = r[0];
  assign div0_o        = is_div & dv_div0;
  assign unsup_o       = is_div & dv_unsup;

endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int ODD_MAX    = 63,
  parameter int RECIP_FRAC = 16,
  parameter int IMM_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic              use_imm,
  input  logic [XLEN-1:0]   rs1,
  input  logic [XLEN-1:0]   rs2,
  input  logic [IMM_W-1:0]  imm,
  output logic [XLEN-1:0]   result,
  output logic [4:0]        flags,
  output logic              out_valid,
  output logic              exc_req,
  output logic [7:0]        exc_vec,
  output logic              div_unsup
);

  logic [XLEN-1:0] operand_b;
  logic [XLEN-1:0] dp_result;
  alu_flags_t      dp_flags;
  logic            dp_div0;
  logic            dp_unsup;
  logic            dp_exc;
  logic [7:0]      dp_vec;

  logic [XLEN-1:0] result_q;
  alu_flags_t      flags_q;
  logic            valid_q, exc_q, unsup_q;
  logic [7:0]      vec_q;

  assign operand_b = use_imm ? {{(XLEN - IMM_W){1'b0}}, imm} : rs2;

  alu_datapath #(.ODD_MAX(ODD_MAX), .FRAC(RECIP_FRAC)) u_dp (
    .op_i    (op),
    .a_i     (rs1),
    .b_i     (operand_b),
    .res_o   (dp_result),
    .flags_o (dp_flags),
    .div0_o  (dp_div0),
    .unsup_o (dp_unsup)
  );

  // divide by zero takes precedence; it never carries overflow
  assign dp_exc = dp_div0 | dp_flags.ovf;
  assign dp_vec = dp_div0 ? VEC_DIV0 : (dp_flags.ovf ? VEC_OVF : 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      flags_q  <= '0;
      valid_q  <= 1'b0;
      exc_q    <= 1'b0;
      unsup_q  <= 1'b0;
      vec_q    <= '0;
    end else begin
      valid_q <= in_valid;
      exc_q   <= in_valid & dp_exc;
      unsup_q <= in_valid & dp_unsup;
      vec_q   <= in_valid ? dp_vec : 8'd0;
      if (in_valid) begin
        result_q <= dp_result;
        flags_q  <= dp_flags;
      end
    end
  end

  assign result    = result_q;
  assign flags     = flags_q;
  assign out_valid = valid_q;
  assign exc_req   = exc_q;
  assign exc_vec   = vec_q;
  assign div_unsup = unsup_q;

endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
  parameter int IMM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [3:0]       op,
  input logic             use_imm,
  input logic [31:0]      rs2,
  input logic [IMM_W-1:0] imm,
  input logic [31:0]      result,
  input logic [4:0]       flags,
  input logic             out_valid,
  input logic             exc_req,
  input logic [7:0]       exc_vec,
  input logic             div_unsup
);

  logic [31:0] b_seen;
  logic        is_logic, is_shift, is_divop, is_spare;

  assign b_seen   = use_imm ? {{(32 - IMM_W){1'b0}}, imm} : rs2;
  assign is_logic = (op == 4'd2) || (op == 4'd3) || (op == 4'd4);
  assign is_shift = (op == 4'd5) || (op == 4'd6) || (op == 4'd7);
  assign is_divop = (op == 4'd10) || (op == 4'd11);
  assign is_spare = (op >= 4'd12);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !exc_req && !div_unsup && exc_vec == 8'd0));
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flags)));
  assert_logic_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_logic) |=> (flags[1:0] == 2'b00));
  assert_shift_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_shift) |=> (flags[1:0] == 2'b00));
  assert_div0_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_divop && b_seen == 32'd0) |=>
      (exc_req && exc_vec == 8'd0 && result == 32'd0 && !flags[1]));
  assert_ovf_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flags[1]) |-> (exc_req && exc_vec == 8'd2));
  assert_unsup_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    div_unsup |-> (!exc_req && result == 32'd0));
  assert_flag_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags[2] == (result == 32'd0) && flags[3] == result[31]
                   && flags[4] == result[0]));
  assert_spare_op_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_spare) |=> (result == 32'd0 && flags == 5'b00100 && !exc_req
                                && !div_unsup));

endmodule

bind int_alu int_alu_checker #(.IMM_W(IMM_W)) u_int_alu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .use_imm   (use_imm),
  .rs2       (rs2),
  .imm       (imm),
  .result    (result),
  .flags     (flags),
  .out_valid (out_valid),
  .exc_req   (exc_req),
  .exc_vec   (exc_vec),
  .div_unsup (div_unsup)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        use_imm = 1'b0;
  logic [31:0] rs1 = '0;
  logic [31:0] rs2 = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic [4:0]  flags;
  logic        out_valid;
  logic        exc_req;
  logic [7:0]  exc_vec;
  logic        div_unsup;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  int_alu u_int_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .use_imm   (use_imm),
    .rs1       (rs1),
    .rs2       (rs2),
    .imm       (imm),
    .result    (result),
    .flags     (flags),
    .out_valid (out_valid),
    .exc_req   (exc_req),
    .exc_vec   (exc_vec),
    .div_unsup (div_unsup)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic        ui;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] im;
    logic [31:0] res;
    logic [4:0]  flg;
    logic        exc;
    logic [7:0]  vec;
    logic        uns;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  // flags {odd, sign, zero, ovf, carry}
  localparam vec_t VT [NV] = '{
    '{4'd0,  1'b0, 32'h5,        32'h7,        16'h0,    32'hC,        5'h00, 1'b0, 8'd0, 1'b0, 4'd3},  // R3
    '{4'd0,  1'b0, 32'hFFFFFFFF, 32'h1,        16'h0,    32'h0,        5'h05, 1'b0, 8'd0, 1'b0, 4'd3},  // R3
    '{4'd0,  1'b0, 32'h7FFFFFFF, 32'h1,        16'h0,    32'h80000000, 5'h0A, 1'b1, 8'd2, 1'b0, 4'd10}, // R10
    '{4'd1,  1'b0, 32'd10,       32'd3,        16'h0,    32'h7,        5'h11, 1'b0, 8'd0, 1'b0, 4'd3},  // R3
    '{4'd1,  1'b0, 32'd3,        32'd10,       16'h0,    32'hFFFFFFF9, 5'h18, 1'b0, 8'd0, 1'b0, 4'd3},  // R3
    '{4'd1,  1'b0, 32'h80000000, 32'h1,        16'h0,    32'h7FFFFFFF, 5'h13, 1'b1, 8'd2, 1'b0, 4'd10}, // R10
    '{4'd2,  1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0,    32'h0FF00FF0, 5'h00, 1'b0, 8'd0, 1'b0, 4'd4},  // R4
    '{4'd3,  1'b1, 32'h12340000, 32'hFFFFFFFF, 16'h5678, 32'h12345678, 5'h00, 1'b0, 8'd0, 1'b0, 4'd2},  // R2
    '{4'd4,  1'b0, 32'h80000001, 32'hFFFFFFFF, 16'h0,    32'h80000001, 5'h18, 1'b0, 8'd0, 1'b0, 4'd4},  // R4
    '{4'd5,  1'b0, 32'h1,        32'h21,       16'h0,    32'h2,        5'h00, 1'b0, 8'd0, 1'b0, 4'd5},  // R5
    '{4'd6,  1'b0, 32'h80000000, 32'h1F,       16'h0,    32'h1,        5'h10, 1'b0, 8'd0, 1'b0, 4'd5},  // R5
    '{4'd7,  1'b0, 32'h80000000, 32'h4,        16'h0,    32'hF8000000, 5'h08, 1'b0, 8'd0, 1'b0, 4'd5},  // R5
    '{4'd8,  1'b0, 32'hFFFFFFFD, 32'h7,        16'h0,    32'hFFFFFFEB, 5'h18, 1'b0, 8'd0, 1'b0, 4'd6},  // R6
    '{4'd8,  1'b0, 32'h10000,    32'h10000,    16'h0,    32'h0,        5'h06, 1'b1, 8'd2, 1'b0, 4'd6},  // R6
    '{4'd9,  1'b0, 32'hFFFFFFFF, 32'h2,        16'h0,    32'hFFFFFFFE, 5'h0A, 1'b1, 8'd2, 1'b0, 4'd6},  // R6
    '{4'd8,  1'b0, 32'hFFFFFFFF, 32'h2,        16'h0,    32'hFFFFFFFE, 5'h08, 1'b0, 8'd0, 1'b0, 4'd6},  // R6
    '{4'd11, 1'b0, 32'd8000,     32'd192,      16'h0,    32'd41,       5'h10, 1'b0, 8'd0, 1'b0, 4'd7},  // R7
    '{4'd11, 1'b1, 32'd100,      32'hFFFFFFFF, 16'd4,    32'd25,       5'h10, 1'b0, 8'd0, 1'b0, 4'd7},  // R7 R2
    '{4'd11, 1'b0, 32'd3,        32'd3,        16'h0,    32'd0,        5'h04, 1'b0, 8'd0, 1'b0, 4'd7},  // R7
    '{4'd11, 1'b0, 32'd6300,     32'd63,       16'h0,    32'd99,       5'h10, 1'b0, 8'd0, 1'b0, 4'd7},  // R7
    '{4'd10, 1'b0, 32'hFFFFE0C0, 32'd192,      16'h0,    32'hFFFFFFD7, 5'h18, 1'b0, 8'd0, 1'b0, 4'd8},  // R8
    '{4'd10, 1'b0, 32'h80000000, 32'hFFFFFFFF, 16'h0,    32'h80000000, 5'h0A, 1'b1, 8'd2, 1'b0, 4'd8},  // R8
    '{4'd10, 1'b0, 32'd7,        32'hFFFFFFFF, 16'h0,    32'hFFFFFFF9, 5'h18, 1'b0, 8'd0, 1'b0, 4'd8},  // R8
    '{4'd11, 1'b0, 32'd5,        32'd0,        16'h0,    32'd0,        5'h04, 1'b1, 8'd0, 1'b0, 4'd9},  // R9
    '{4'd10, 1'b1, 32'd7,        32'd9,        16'h0,    32'd0,        5'h04, 1'b1, 8'd0, 1'b0, 4'd9},  // R9
    '{4'd11, 1'b0, 32'd1000,     32'd65,       16'h0,    32'd0,        5'h04, 1'b0, 8'd0, 1'b1, 4'd11}, // R11
    '{4'd12, 1'b0, 32'd5,        32'd5,        16'h0,    32'd0,        5'h04, 1'b0, 8'd0, 1'b0, 4'd13}, // R13
    '{4'd15, 1'b0, 32'hFF,       32'hFF,       16'h0,    32'd0,        5'h04, 1'b0, 8'd0, 1'b0, 4'd13}, // R13
    '{4'd9,  1'b0, 32'h10000,    32'hFFFF,     16'h0,    32'hFFFF0000, 5'h08, 1'b0, 8'd0, 1'b0, 4'd6}   // R6 R12
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_idle_outputs(input string tag);
    chk({tag, " out_valid"}, 32'(out_valid), 32'd0);
    chk({tag, " exc_req"},   32'(exc_req),   32'd0);
    chk({tag, " exc_vec"},   32'(exc_vec),   32'd0);
    chk({tag, " div_unsup"}, 32'(div_unsup), 32'd0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check_idle_outputs("R1 reset");
    chk("R1 reset result", result, 32'd0);
    chk("R1 reset flags", 32'(flags), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table, issued back to back; each result sampled one cycle later
    for (int i = 0; i < NV; i++) begin
      op = VT[i].op; use_imm = VT[i].ui; rs1 = VT[i].a; rs2 = VT[i].b; imm = VT[i].im;
      in_valid = 1'b1;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d result", VT[i].req, i), result, VT[i].res);
      chk($sformatf("R12 vec%0d flags", i), 32'(flags), 32'(VT[i].flg));
      chk($sformatf("R%0d vec%0d exc_req", VT[i].req, i), 32'(exc_req), 32'(VT[i].exc));
      if (VT[i].exc)
        chk($sformatf("R%0d vec%0d exc_vec", VT[i].req, i), 32'(exc_vec), 32'(VT[i].vec));
      chk($sformatf("R%0d vec%0d div_unsup", VT[i].req, i), 32'(div_unsup), 32'(VT[i].uns));
      chk($sformatf("R1 vec%0d out_valid", i), 32'(out_valid), 32'd1);
    end

    // R1: idle cycles hold result and flags even when operands change
    in_valid = 1'b0;
    op = 4'd0; rs1 = 32'h7FFFFFFF; rs2 = 32'h1;
    @(negedge clk);
    check_idle_outputs("R1 idle");
    chk("R1 idle result held", result, 32'hFFFF0000);
    chk("R1 idle flags held", 32'(flags), 32'h08);
    @(negedge clk);
    chk("R1 idle result still held", result, 32'hFFFF0000);

    // R10 after idle: overflow exception clears on the following idle cycle
    in_valid = 1'b1;
    @(negedge clk);
    chk("R10 add overflow exc_vec", 32'(exc_vec), 32'd2);
    chk("R10 add overflow exc_req", 32'(exc_req), 32'd1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 exc_req drops when idle", 32'(exc_req), 32'd0);

    // R2: rs2 ignored when immediate selected (rs2 all ones, imm zero => div by zero)
    op = 4'd11; use_imm = 1'b1; rs1 = 32'd50; rs2 = 32'hFFFFFFFF; imm = 16'd0;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R2 R9 imm zero divisor exc_req", 32'(exc_req), 32'd1);
    chk("R2 R9 imm zero divisor result", result, 32'd0);
    in_valid = 1'b0;

    // R1: reset in the middle of operation clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check_idle_outputs("R1 second reset");
    chk("R1 second reset result", result, 32'd0);
    chk("R1 second reset flags", 32'(flags), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule